// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of eight 32-bit cycle counters for performance monitoring. A shared 16-bit event vector comes in from the rest of the chip. Each counter has a 3-bit selector that picks one of eight events. The wiring is fixed per counter, so each counter sees its own subset of the vector rather than the whole of it. While the bank is running, a counter adds one on every clock in which its chosen event is high. A single control bit halts the whole bank.

Software reaches the block through a simple register port. The port has a write strobe with address and data, and a separate read address with a combinational read-data output. Through it software can preload counters, program the selectors, start and halt the bank, and read the overflow status. When a counter wraps past its maximum value it sets a sticky flag. The interrupt output is high whenever any flag is set. Software clears flags by writing ones to their bit positions.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every counter reads 0, the control register (address 8) reads 1 (halted), the select register (address 9) reads 0, the status register (address 10) reads 0, and `irq` is low.
- R2: While running (address 8, bit 0 = 0), a counter increases by exactly one on each clock edge at which its selected event is high, and holds otherwise.
- R3: While halted (address 8, bit 0 = 1), no counter changes except through a software write.
- R4: Counter i with select value s watches event bit (i + 2*s) mod 16. The select value for counter i occupies bits 3i+2:3i of address 9, which reads back as written.
- R5: A write to address i (0 to 7) loads counter i with the written data, and this load takes priority over an increment in the same cycle.
- R6: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its flag, bit i of address 10.
- R7: A write to address 10 clears every flag whose data bit is 1; flags whose data bit is 0 stay unchanged.
- R8: If a counter overflows in the same cycle that its flag is written with 1, the flag ends up set.
- R9: `irq` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| events | input | 16 | Shared event vector |
| irq | output | 1 | OR of all overflow flags |

## Verification
A wrong routing of events or a dropped increment shows up in the counter values read after a counting window. Each sweep of the select value exposes it as soon as the bank is halted. A flag that is wrongly set, cleared or kept appears on the status register and on `irq` one clock after the edge that should have changed it. The overflow/clear collision and the write/increment collision are each forced on a single named edge, so a wrong priority shows at the very next read.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int NUM_CTR = 8;
    localparam int CTR_W   = 32;
    localparam int SEL_W   = 3;
    localparam int SEL_N   = 1 << SEL_W;
    localparam int EVT_W   = 16;
    localparam int STRIDE  = 2;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_CTR);
    localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(NUM_CTR + 1);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(NUM_CTR + 2);

    typedef logic [CTR_W-1:0]              ctr_t;
    typedef logic [NUM_CTR-1:0][SEL_W-1:0] sel_bank_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic int evt_index(input int ctr, input int s);
        return (ctr + STRIDE * s) % EVT_W;
    endfunction
endpackage

// File: rtl/evcnt_route.sv
module evcnt_route
    import evcnt_pkg::*;
(
    input  logic [EVT_W-1:0]   events,
    input  sel_bank_t          sel,
    output logic [NUM_CTR-1:0] hit
);
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic [SEL_N-1:0] cand;
        for (genvar s = 0; s < SEL_N; s++) begin : g_src
            assign cand[s] = events[evt_index(i, s)];
        end
        assign hit[i] = cand[sel[i]];
    end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter
    import evcnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic ld,
    input  ctr_t ld_val,
    output ctr_t cnt,
    output logic ovf
);
    assign ovf = inc && !ld && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val)));                                      // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld) |=> $stable(cnt));                                     // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && cnt == '1) |=> (cnt == '0));                          // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));           // R2
endmodule

// File: rtl/evcnt_flags.sv
module evcnt_flags
    import evcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] set,
    input  logic [NUM_CTR-1:0] clr,
    output logic [NUM_CTR-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));               // R8
    AST_CLR_DROP: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));       // R7
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((flags & $past(flags)) == $past(flags)));           // R7
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [EVT_W-1:0]  events,
    output logic              irq
);
    localparam int SEL_BITS = NUM_CTR * SEL_W;

    reg_wr_t              wr;
    logic                 halt_q;
    sel_bank_t            sel_q;
    logic [NUM_CTR-1:0]   hit;
    logic [NUM_CTR-1:0]   ovf;
    logic [NUM_CTR-1:0]   clr;
    logic [NUM_CTR-1:0]   flags;
    ctr_t                 cnt [NUM_CTR];

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b1;
            sel_q  <= '0;
        end else if (wr.en) begin
            if (wr.addr == ADDR_CTRL) halt_q <= wr.data[0];
            if (wr.addr == ADDR_SEL)  sel_q  <= wr.data[SEL_BITS-1:0];
        end
    end

    evcnt_route u_route (
        .events (events),
        .sel    (sel_q),
        .hit    (hit)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_cnt
        logic ld;
        assign ld = wr.en && (wr.addr == ADDR_W'(i));
        evcnt_counter u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc    (hit[i] && !halt_q),
            .ld     (ld),
            .ld_val (wr.data[CTR_W-1:0]),
            .cnt    (cnt[i]),
            .ovf    (ovf[i])
        );
    end

    assign clr = (wr.en && wr.addr == ADDR_STAT) ? wr.data[NUM_CTR-1:0] : '0;

    evcnt_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (ovf),
        .clr   (clr),
        .flags (flags)
    );

    assign irq = |flags;

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NUM_CTR))  rd_data = DATA_W'(cnt[rd_addr[SEL_W-1:0]]);
        else if (rd_addr == ADDR_CTRL)   rd_data = DATA_W'(halt_q);
        else if (rd_addr == ADDR_SEL)    rd_data = DATA_W'(sel_q);
        else if (rd_addr == ADDR_STAT)   rd_data = DATA_W'(flags);
    end

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en && wr_addr == ADDR_STAT));                // R9
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(ovf) != '0));                                  // R9
endmodule

// File: tb/sim_evcnt_bank.sv
`timescale 1ns/1ps
module sim_evcnt_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] events = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_cnt [8];

    always #10 clk = ~clk;

    evcnt_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .events(events), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string req);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== e) begin
            fails++;
            $display("FAIL %s addr %0d: actual 0x%08h expected 0x%08h", req, a, rd_data, e);
        end
    endtask

    task automatic irq_chk(input logic e, input string req);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq: actual %0b expected %0b", req, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        for (int i = 0; i < 8; i++) rd_chk(4'(i), 32'h0, "R1");
        rd_chk(4'd8, 32'h1, "R1");
        rd_chk(4'd9, 32'h0, "R1");
        rd_chk(4'd10, 32'h0, "R1");
        irq_chk(1'b0, "R1");

        // R2 / R4 sweep over every select value
        for (int s = 0; s < 8; s++) begin
            logic [31:0] selv = '0;
            for (int i = 0; i < 8; i++) begin
                wr(4'(i), 32'h0);
                exp_cnt[i] = 32'h0;
                selv = selv | (32'(s) << (3 * i));
            end
            wr(4'd9, selv);
            wr(4'd8, 32'h0);
            for (int c = 0; c < 24; c++) begin
                logic [15:0] ev = 16'((c * 40503 + s * 1231) ^ (c << 3));
                events = ev;
                for (int i = 0; i < 8; i++)
                    if (ev[(i + 2 * s) % 16]) exp_cnt[i] = exp_cnt[i] + 1;
                step();
            end
            events = '0;
            wr(4'd8, 32'h1);
            for (int i = 0; i < 8; i++) rd_chk(4'(i), exp_cnt[i], "R2/R4");
        end

        // R4 select field readback
        wr(4'd9, 32'h00FAC688);
        rd_chk(4'd9, 32'h00FAC688, "R4");
        wr(4'd9, 32'h0);

        // R5 preload, R3 halt holds
        wr(4'd3, 32'hFFFF_FFFE);
        rd_chk(4'd3, 32'hFFFF_FFFE, "R5");
        events = 16'hFFFF;
        repeat (5) step();
        events = '0;
        rd_chk(4'd3, 32'hFFFF_FFFE, "R3");
        rd_chk(4'd10, 32'h0, "R3");

        // R2 / R6 / R9 overflow of counter 3
        wr(4'd8, 32'h0);
        rd_chk(4'd8, 32'h0, "R3");
        events = 16'h0008;
        step();
        rd_chk(4'd3, 32'hFFFF_FFFF, "R2");
        rd_chk(4'd10, 32'h0, "R6");
        irq_chk(1'b0, "R9");
        step();
        events = '0;
        rd_chk(4'd3, 32'h0, "R6");
        rd_chk(4'd10, 32'h08, "R6");
        irq_chk(1'b1, "R9");

        // R7 zero bits keep flags
        wr(4'd10, 32'h00);
        rd_chk(4'd10, 32'h08, "R7");
        wr(4'd10, 32'hF7);
        rd_chk(4'd10, 32'h08, "R7");

        // second flag, then selective clear
        wr(4'd5, 32'hFFFF_FFFF);
        events = 16'h0020;
        step();
        events = '0;
        rd_chk(4'd10, 32'h28, "R6");
        wr(4'd10, 32'h08);
        rd_chk(4'd10, 32'h20, "R7");
        irq_chk(1'b1, "R9");

        // R8 overflow and clear in the same cycle; flag 6 is clear-only
        wr(4'd5, 32'hFFFF_FFFF);
        events = 16'h0020;
        wr(4'd10, 32'h60);
        events = '0;
        rd_chk(4'd10, 32'h20, "R8");
        rd_chk(4'd5, 32'h0, "R8");
        irq_chk(1'b1, "R8");

        // R5 load beats increment in the same cycle
        events = 16'h0004;
        wr(4'd2, 32'h100);
        rd_chk(4'd2, 32'h100, "R5");
        step();
        events = '0;
        rd_chk(4'd2, 32'h101, "R5");

        // R9 last flag cleared drops irq
        wr(4'd10, 32'h20);
        rd_chk(4'd10, 32'h0, "R7");
        irq_chk(1'b0, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule